// File: doc/BRIEF.md
# Single-Address DMA Transfer Channel

This block is one DMA channel that moves data between memory and an external device. Only one address is ever driven: the memory address. The device takes part through an acknowledge strobe instead of a second address. The acknowledge acts as a write strobe into the device when memory is the source, and as a read strobe out of the device when memory is the destination. The memory enable that goes with it always has the opposite sense to the device side.

Software first loads a 24-bit memory address, a transfer count and a control word through a small write-only register port. It then pulses `start`. Each transfer takes two bus cycles. In the first cycle the address, the acknowledge and one memory enable are driven. In the second cycle the address is held with every strobe low while data settles. After each transfer the address advances by the transfer size and the count drops by one. When the count runs out, the channel goes idle and sets a sticky completion flag. Only sequential operation is modelled.

Top module: `sadma_channel`

## Requirements
- R1: After reset, `mem_addr` is 0, and `active`, `done`, `dev_ack`, `mem_rd` and `mem_wr` are all 0.
- R2: A transfer takes two cycles. In the first, `dev_ack` is 1 along with one memory enable. In the second, `dev_ack`, `mem_rd` and `mem_wr` are 0 and `mem_addr` does not change. The first strobe cycle follows directly on the clock edge that samples `start`.
- R3: Control bit 0 selects the direction. With it at 0, memory is the source, so `mem_rd`=1 and `mem_wr`=0 while `dev_ack` is 1. With it at 1, memory is the destination, so `mem_wr`=1 and `mem_rd`=0 while `dev_ack` is 1.
- R4: After each transfer `mem_addr` advances by 1 when control bit 1 is 0 (byte) or by 2 when it is 1 (word). The address wraps modulo 2^24.
- R5: A start with count N>0 produces exactly N strobe cycles. After the last one, `active` falls and `done` rises on the same edge.
- R6: `done` stays 1 until a write with `cfg_sel`=3. That write clears it.
- R7: A start with a loaded count of 0 sets `done` on the next edge and produces no strobe cycle.
- R8: A start is ignored when control bit 2 (single-address enable) or control bit 3 (short-address mode) is 0. In that case there is no strobe and `done` stays 0.
- R9: A `start` pulse while `active` is 1 has no effect on the number of transfers.
- R10: While `active` is 1, writes to the address (`cfg_sel`=0), the count (`cfg_sel`=1) and the control word (`cfg_sel`=2) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 address, 1 count, 2 control, 3 clear done |
| cfg_wdata | input | 24 | Register write data |
| start | input | 1 | Start request pulse |
| mem_addr | output | 24 | Memory address (current transfer) |
| mem_rd | output | 1 | Memory read enable (direction 0) |
| mem_wr | output | 1 | Memory write enable (direction 1) |
| dev_ack | output | 1 | Device acknowledge strobe |
| active | output | 1 | Channel busy with a transfer sequence |
| done | output | 1 | Sticky completion flag |

## Verification
On every cycle the assertions check three things. First, the acknowledge always pairs with the memory enable of the correct sense, and every strobe cycle is followed by a quiet hold cycle. Second, the address and count step exactly once per completed transfer. Third, the completion flag stays sticky and a zero-count start finishes at once. Only the bench scenarios can show the following: the total number of transfers matches the loaded count, the address sequence is right across a 24-bit wrap, and starts and register writes made during a run leave the run unchanged. They also show that a channel with either mode bit clear never starts.

// File: rtl/sadma_pkg.sv
package sadma_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_DRIVE = 2'd1,
      PH_HOLD  = 2'd2
   } bus_phase_e;

   localparam logic [1:0] SEL_ADDR  = 2'd0;
   localparam logic [1:0] SEL_COUNT = 2'd1;
   localparam logic [1:0] SEL_CTRL  = 2'd2;
   localparam logic [1:0] SEL_CLEAR = 2'd3;

   localparam int CB_DIR   = 0;
   localparam int CB_WORD  = 1;
   localparam int CB_SAE   = 2;
   localparam int CB_SHORT = 3;
   localparam int CB_COUNT = 4;
endpackage

// File: rtl/sadma_ctrl_regs.sv
module sadma_ctrl_regs
   import sadma_pkg::*;
#(
   parameter int CFG_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [1:0]       cfg_sel,
   input  logic [CFG_W-1:0] cfg_wdata,
   input  logic             busy,
   input  logic             finish,
   output logic             dir,
   output logic             word,
   output logic             mode_ok,
   output logic             done
);
   logic [CB_COUNT-1:0] ctrl_q;
   logic                ctrl_we;
   logic                clr_we;

   assign ctrl_we = cfg_wr && (cfg_sel == SEL_CTRL) && !busy;
   assign clr_we  = cfg_wr && (cfg_sel == SEL_CLEAR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (ctrl_we) begin
         ctrl_q <= cfg_wdata[CB_COUNT-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done <= 1'b0;
      end else if (finish) begin
         done <= 1'b1;
      end else if (clr_we) begin
         done <= 1'b0;
      end
   end

   assign dir     = ctrl_q[CB_DIR];
   assign word    = ctrl_q[CB_WORD];
   assign mode_ok = ctrl_q[CB_SAE] && ctrl_q[CB_SHORT];

   // R6: completion flag is sticky until an explicit clear
   p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !clr_we) |=> done);

   // R10: control word frozen while the channel runs
   p_ctrl_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(ctrl_q));
endmodule

// File: rtl/sadma_xfer_ctr.sv
module sadma_xfer_ctr #(
   parameter int ADDR_W  = 24,
   parameter int CNT_W   = 16,
   parameter int CFG_W   = 24,
   parameter bit WORD_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_addr,
   input  logic              load_cnt,
   input  logic [CFG_W-1:0]  wdata,
   input  logic              step,
   input  logic              word,
   output logic [ADDR_W-1:0] addr,
   output logic              cnt_zero,
   output logic              cnt_last
);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0]  cnt_q;
   logic [ADDR_W-1:0] incr;

   generate
      if (WORD_EN) begin : g_sized
         assign incr = word ? ADDR_W'(2) : ADDR_W'(1);
      end else begin : g_byte_only
         assign incr = ADDR_W'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr <= '0;
      end else if (load_addr) begin
         addr <= wdata[ADDR_W-1:0];
      end else if (step) begin
         addr <= addr + incr;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_cnt) begin
         cnt_q <= wdata[CNT_W-1:0];
      end else if (step) begin
         cnt_q <= cnt_q - CNT_ONE;
      end
   end

   assign cnt_zero = (cnt_q == '0);
   assign cnt_last = (cnt_q == CNT_ONE);

   // R4: address advances by the transfer size once per transfer
   p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load_addr) |=> addr == ADDR_W'($past(addr) + (($past(word) && WORD_EN) ? 2 : 1)));

   // R5: count never decremented from zero
   p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> !cnt_zero);
endmodule

// File: rtl/sadma_seq.sv
module sadma_seq
   import sadma_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic mode_ok,
   input  logic cnt_zero,
   input  logic cnt_last,
   input  logic dir,
   output logic busy,
   output logic step,
   output logic finish,
   output logic dev_ack,
   output logic mem_rd,
   output logic mem_wr
);
   bus_phase_e phase_q, phase_d;
   logic       launch;

   assign launch = (phase_q == PH_IDLE) && start && mode_ok;

   always_comb begin
      phase_d = phase_q;
      step    = 1'b0;
      finish  = 1'b0;
      unique case (phase_q)
         PH_IDLE: begin
            if (launch) begin
               if (cnt_zero) finish = 1'b1;
               else          phase_d = PH_DRIVE;
            end
         end
         PH_DRIVE: phase_d = PH_HOLD;
         PH_HOLD: begin
            step = 1'b1;
            if (cnt_last) begin
               finish  = 1'b1;
               phase_d = PH_IDLE;
            end else begin
               phase_d = PH_DRIVE;
            end
         end
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= PH_IDLE;
      else        phase_q <= phase_d;
   end

   assign busy    = (phase_q != PH_IDLE);
   assign dev_ack = (phase_q == PH_DRIVE);
   assign mem_rd  = dev_ack && !dir;
   assign mem_wr  = dev_ack && dir;

   // R2: every strobe cycle is followed by a quiet hold cycle
   p_strobe_then_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dev_ack |=> (!dev_ack && !mem_rd && !mem_wr && busy));

   // R9: a start while busy cannot restart or end the sequence early
   p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !cnt_last) |=> busy);
endmodule

// File: rtl/sadma_channel.sv
module sadma_channel
   import sadma_pkg::*;
#(
   parameter int ADDR_W  = 24,
   parameter int CNT_W   = 16,
   parameter int CFG_W   = 24,
   parameter bit WORD_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [1:0]        cfg_sel,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic              start,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              dev_ack,
   output logic              active,
   output logic              done
);
   generate
      if (ADDR_W < 2 || CNT_W < 1) begin : g_bad_width
         $error("sadma_channel: address or count width too small");
      end
      if (CFG_W < ADDR_W || CFG_W < CNT_W || CFG_W < CB_COUNT) begin : g_bad_cfg
         $error("sadma_channel: write data narrower than a register");
      end
   endgenerate

   logic busy, step, finish;
   logic dir, word, mode_ok;
   logic cnt_zero, cnt_last;
   logic load_addr, load_cnt;

   assign load_addr = cfg_wr && (cfg_sel == SEL_ADDR)  && !busy;
   assign load_cnt  = cfg_wr && (cfg_sel == SEL_COUNT) && !busy;

   sadma_ctrl_regs #(.CFG_W(CFG_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_wr   (cfg_wr),
      .cfg_sel  (cfg_sel),
      .cfg_wdata(cfg_wdata),
      .busy     (busy),
      .finish   (finish),
      .dir      (dir),
      .word     (word),
      .mode_ok  (mode_ok),
      .done     (done)
   );

   sadma_xfer_ctr #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W),
      .CFG_W  (CFG_W),
      .WORD_EN(WORD_EN)
   ) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_addr(load_addr),
      .load_cnt (load_cnt),
      .wdata    (cfg_wdata),
      .step     (step),
      .word     (word),
      .addr     (mem_addr),
      .cnt_zero (cnt_zero),
      .cnt_last (cnt_last)
   );

   sadma_seq u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .mode_ok (mode_ok),
      .cnt_zero(cnt_zero),
      .cnt_last(cnt_last),
      .dir     (dir),
      .busy    (busy),
      .step    (step),
      .finish  (finish),
      .dev_ack (dev_ack),
      .mem_rd  (mem_rd),
      .mem_wr  (mem_wr)
   );

   assign active = busy;

   // R3: memory enable sense opposite to the device strobe, set by direction
   p_strobe_sense_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dev_ack |-> (mem_rd == !dir) && (mem_wr == dir));

   // R8: no bus activity unless both mode bits are set
   p_mode_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dev_ack |-> mode_ok);

   // R7: zero-count start completes on the next edge without activity
   p_zero_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && mode_ok && cnt_zero) |=> (done && !active && !dev_ack));

   // R10: address frozen during the strobe/hold pair
   p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      dev_ack |=> $stable(mem_addr));
endmodule

// File: tb/test_sadma_channel.sv
module test_sadma_channel;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [1:0]  cfg_sel = 2'd0;
   logic [23:0] cfg_wdata = '0;
   logic        start = 1'b0;
   logic [23:0] mem_addr;
   logic        mem_rd, mem_wr, dev_ack, active, done;

   int n_total = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   sadma_channel i_sadma_channel (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .start(start), .mem_addr(mem_addr),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .dev_ack(dev_ack),
      .active(active), .done(done)
   );

   function automatic logic [23:0] next_addr(input logic [23:0] a, input bit w);
      return a + (w ? 24'd2 : 24'd1);
   endfunction

   function automatic logic [23:0] ctrl_word(input bit d, input bit w, input bit sae, input bit sh);
      return {20'd0, sh, sae, w, d};
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_total++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [1:0] sel, input logic [23:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic run(input logic [23:0] a0, input int cnt, input bit d, input bit w, input bit poke);
      logic [23:0] exp_a, prev_a;
      bit prev_ack;
      int n;
      wr_reg(2'd3, 24'd0);
      wr_reg(2'd0, a0);
      wr_reg(2'd1, 24'(cnt));
      wr_reg(2'd2, ctrl_word(d, w, 1'b1, 1'b1));
      chk(done == 1'b0, "R6 cleared", int'(done), 0);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      exp_a = a0; prev_a = '0; prev_ack = 1'b0; n = 0;
      for (int cyc = 0; cyc < 400; cyc++) begin
         if (prev_ack)
            chk(!dev_ack && !mem_rd && !mem_wr && mem_addr == prev_a, "R2 hold",
                int'({dev_ack, mem_rd, mem_wr}), 0);
         if (dev_ack) begin
            chk(mem_addr == exp_a, "R4 addr", int'(mem_addr), int'(exp_a));
            chk(mem_rd == !d && mem_wr == d, "R3 sense", int'({mem_rd, mem_wr}), int'({!d, d}));
            n++;
            prev_a = mem_addr;
            exp_a = next_addr(exp_a, w);
         end
         prev_ack = dev_ack;
         if (!active && !dev_ack) break;
         if (poke) begin
            // R9 / R10: start and register writes during the run
            if (cyc == 1) begin start = 1'b1; cfg_wr = 1'b1; cfg_sel = 2'd0; cfg_wdata = 24'h123456; end
            if (cyc == 2) begin start = 1'b0; cfg_sel = 2'd1; cfg_wdata = 24'd40; end
            if (cyc == 3) begin cfg_sel = 2'd2; cfg_wdata = 24'd0; end
            if (cyc == 4) cfg_wr = 1'b0;
         end
         @(negedge clk);
      end
      chk(n == cnt, poke ? "R9 R10 count" : "R5 count", n, cnt);
      chk(done == 1'b1 && active == 1'b0, cnt == 0 ? "R7 done" : "R5 done",
          int'({done, active}), 2);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++; n_total++;
         $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
         $display("%0d/%0d checks passed", n_total - n_fail, n_total);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed));
      repeat (3) @(negedge clk);
      chk(mem_addr == 0 && !active && !done && !dev_ack && !mem_rd && !mem_wr, "R1 reset",
          int'({mem_addr, active, done, dev_ack, mem_rd, mem_wr}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(mem_addr == 0 && !active && !done && !dev_ack, "R1 after release",
          int'({active, done, dev_ack}), 0);

      run(24'h000100, 3, 1'b0, 1'b0, 1'b0);
      run(24'h000200, 4, 1'b1, 1'b1, 1'b0);
      run(24'hFFFFFE, 3, 1'b0, 1'b1, 1'b0);
      run(24'hFFFFFF, 2, 1'b1, 1'b0, 1'b0);
      run(24'h000040, 0, 1'b0, 1'b0, 1'b0);

      // R6: done sticky, then cleared by select 3
      repeat (3) @(negedge clk);
      chk(done == 1'b1, "R6 sticky", int'(done), 1);
      wr_reg(2'd3, 24'd0);
      chk(done == 1'b0, "R6 clear", int'(done), 0);

      // R9 R10: pokes during an active run
      run(24'h000800, 5, 1'b0, 1'b0, 1'b1);
      run(24'h000900, 2, 1'b1, 1'b0, 1'b0);

      // R8: either mode bit clear keeps the channel idle
      for (int k = 0; k < 2; k++) begin
         bit any_ack;
         wr_reg(2'd3, 24'd0);
         wr_reg(2'd1, 24'd3);
         wr_reg(2'd2, ctrl_word(1'b0, 1'b0, k == 1, k == 0));
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         any_ack = 1'b0;
         for (int c = 0; c < 8; c++) begin
            any_ack |= dev_ack | active;
            @(negedge clk);
         end
         chk(!any_ack && !done, "R8 idle", int'({any_ack, done}), 0);
      end

      for (int it = 0; it < 20; it++) begin
         logic [23:0] a;
         int c;
         a = 24'($urandom);
         if (it % 5 == 0) a = 24'hFFFFFD;
         c = int'($urandom % 7);
         run(a, c, bit'($urandom % 2), bit'($urandom % 2), 1'b0);
      end

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end
endmodule